// File: doc/BRIEF.md
# UART Modem Status Register with Loopback

This block keeps the modem status byte of a 16550-style serial port. Each clock it samples four modem input lines (clear-to-send, data-set-ready, carrier detect and ring indicator) and stores their levels in the upper half of the byte. When a line changes, a sticky change flag is set for it in the lower half. The ring flag is set only when the ring line falls from 1 to 0. The change flags stay set until the host reads the register. The read strobe marks the cycle in which the host takes the byte. The flags clear at the edge that ends that cycle, unless a new change arrives in the same cycle, in which case the new change wins.

In loopback mode the byte the host reads is built from the four modem control outputs instead of the pins. The stored levels and flags are frozen during loopback: pin activity is ignored and a read does not clear the flags. When loopback ends, the pins are compared against the frozen levels, so a line that moved in the meantime still produces its change flag. The any-change output is the OR of the stored flags and feeds the interrupt logic elsewhere. Input synchronisation and interrupt priority are not part of this block.

Top module: `modem_status_reg`

## Requirements
- R1: Out of reset, with loopback off, `statusByte` reads 0xB0 (carrier, data-set-ready and clear-to-send levels set, ring level and all change flags clear) and `anyDelta` is 0.
- R2: Outside loopback, `statusByte` bits 7,6,5,4 hold the levels of carrier, ring, data-set-ready and clear-to-send as sampled at the previous edge. Any change of carrier, data-set-ready or clear-to-send sets its flag (bit 3, 1, 0 respectively) from the next edge on.
- R3: The ring flag (bit 2) is set by a 1-to-0 transition of the ring line and never by a 0-to-1 transition.
- R4: During a cycle with `rdStb` high and loopback off, `statusByte` still shows the flags. At the following edge bits 3:0 clear, provided no line changes in that cycle.
- R5: A line event sampled in the same cycle as a read strobe sets its flag at that edge; the event is not lost to the clear.
- R6: Change flags accumulate: once set, a flag stays set through any further line activity until a read outside loopback clears it.
- R7: In loopback, `statusByte` = {mcrBits[3], mcrBits[2], mcrBits[0], mcrBits[1], 4'b0000}. Here mcrBits[3:0] are out2, out1, request-to-send and data-terminal-ready.
- R8: In loopback the stored levels and flags are held: pin changes set no flag and `rdStb` clears nothing. After loopback ends, the pins are compared against the held levels.
- R9: `anyDelta` is the OR of the four stored change flags, and stays valid during loopback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctsIn | input | 1 | Clear-to-send line level |
| dsrIn | input | 1 | Data-set-ready line level |
| dcdIn | input | 1 | Carrier detect line level |
| riIn | input | 1 | Ring indicator line level |
| mcrBits | input | 4 | Modem control outputs: [3] out2, [2] out1, [1] request-to-send, [0] data-terminal-ready |
| loopEn | input | 1 | Loopback mode |
| rdStb | input | 1 | Host reads the status byte this cycle |
| statusByte | output | 8 | Status byte as seen by the host |
| anyDelta | output | 1 | At least one change flag is set |

## Verification
The hardest situation to reach is a change that lands in exactly the cycle of a read strobe. This includes a falling ring edge, and the case where loopback is left while the pins differ from the levels frozen on entry. The bench drives these coincidences on purpose. It also runs a long stretch of random pin, strobe and loopback activity against a behavioural model that is compared every cycle. That stretch covers overlaps that nobody wrote down.

// File: rtl/msr_pkg.sv
package msr_pkg;
  // Line order inside every LINE_COUNT vector: [3] carrier, [2] ring, [1] dsr, [0] cts
  localparam int LINE_COUNT = 4;
  localparam int BYTE_W = 2 * LINE_COUNT;
  localparam logic [LINE_COUNT-1:0] LEVEL_RESET = 4'b1011;
  localparam logic [LINE_COUNT-1:0] FALL_ONLY = 4'b0100;

  typedef struct packed {
    logic sampleEn;
    logic clrDelta;
  } msr_strobe_t;
endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic        loopEn,
  input  logic        rdStb,
  output msr_strobe_t strb
);
  always_comb begin
    strb.sampleEn = ~loopEn;
    strb.clrDelta = rdStb & ~loopEn;
  end
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int LINES = LINE_COUNT,
  parameter logic [LINES-1:0] RESET_LVL = LEVEL_RESET,
  parameter logic [LINES-1:0] FALL_MASK = FALL_ONLY
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   lineIn,
  input  logic [LINES-1:0]   loopView,
  input  logic               loopEn,
  input  msr_strobe_t        strb,
  output logic [2*LINES-1:0] statusByte,
  output logic               anyDelta
);
  logic [LINES-1:0] levelQ;
  logic [LINES-1:0] deltaQ;
  logic [LINES-1:0] edgeHit;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (FALL_MASK[i]) begin : g_fall
      assign edgeHit[i] = levelQ[i] & ~lineIn[i];

      p_fall_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
        (strb.sampleEn && levelQ[i] && !lineIn[i]) |=> deltaQ[i]);
      p_rise_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
        (strb.sampleEn && !levelQ[i] && lineIn[i] && !deltaQ[i]) |=> !deltaQ[i]);
    end else begin : g_both
      assign edgeHit[i] = levelQ[i] ^ lineIn[i];

      p_change_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
        (strb.sampleEn && (levelQ[i] != lineIn[i])) |=> deltaQ[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= RESET_LVL;
      deltaQ <= '0;
    end else if (strb.sampleEn) begin
      levelQ <= lineIn;
      deltaQ <= (strb.clrDelta ? '0 : deltaQ) | edgeHit;
    end
  end

  always_comb begin
    if (loopEn) statusByte = {loopView, {LINES{1'b0}}};
    else        statusByte = {levelQ, deltaQ};
    anyDelta = |deltaQ;
  end

  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrDelta && (lineIn == levelQ)) |=> (deltaQ == '0));
  p_event_beats_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrDelta && ((levelQ & ~lineIn) != '0)) |=> (deltaQ != '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sampleEn && !strb.clrDelta) |=> ((deltaQ & $past(deltaQ)) == $past(deltaQ)));
  p_loop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sampleEn) |=> ($stable(levelQ) && $stable(deltaQ)));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsIn,
  input  logic       dsrIn,
  input  logic       dcdIn,
  input  logic       riIn,
  input  logic [3:0] mcrBits,
  input  logic       loopEn,
  input  logic       rdStb,
  output logic [7:0] statusByte,
  output logic       anyDelta
);
  msr_strobe_t strb;
  logic [LINE_COUNT-1:0] lineIn;
  logic [LINE_COUNT-1:0] loopView;

  // out2 -> carrier, out1 -> ring, dtr -> dsr, rts -> cts
  assign lineIn   = {dcdIn, riIn, dsrIn, ctsIn};
  assign loopView = {mcrBits[3], mcrBits[2], mcrBits[0], mcrBits[1]};

  msr_ctrl u_ctrl (
    .loopEn (loopEn),
    .rdStb  (rdStb),
    .strb   (strb)
  );

  msr_datapath #(
    .LINES     (LINE_COUNT),
    .RESET_LVL (LEVEL_RESET),
    .FALL_MASK (FALL_ONLY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .loopView   (loopView),
    .loopEn     (loopEn),
    .strb       (strb),
    .statusByte (statusByte),
    .anyDelta   (anyDelta)
  );

  p_any_delta_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEn) |-> (anyDelta == (|statusByte[3:0])));
  p_loop_low_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> (statusByte[3:0] == 4'b0000));
endmodule

// File: tb/test_modem_status_reg.sv
module test_modem_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsIn = 1'b1, dsrIn = 1'b1, dcdIn = 1'b1, riIn = 1'b0;
  logic [3:0] mcrBits = 4'h0;
  logic loopEn = 1'b0, rdStb = 1'b0;
  logic [7:0] statusByte;
  logic anyDelta;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mCar = 1, mRing = 0, mDsr = 1, mCts = 1;
  bit fCar = 0, fRing = 0, fDsr = 0, fCts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_reg i_modem_status_reg (
    .clk(clk), .rstN(rstN), .ctsIn(ctsIn), .dsrIn(dsrIn), .dcdIn(dcdIn),
    .riIn(riIn), .mcrBits(mcrBits), .loopEn(loopEn), .rdStb(rdStb),
    .statusByte(statusByte), .anyDelta(anyDelta)
  );

  function automatic logic [7:0] expByte();
    if (loopEn) return {mcrBits[3], mcrBits[2], mcrBits[0], mcrBits[1], 4'b0000};
    return {mCar, mRing, mDsr, mCts, fCar, fRing, fDsr, fCts};
  endfunction

  task automatic checkNow();
    logic [7:0] e;
    logic ea;
    e = expByte();
    ea = fCar | fRing | fDsr | fCts;
    checks++;
    if (statusByte !== e) begin
      bad++;
      $display("FAIL %s statusByte actual=%02h expected=%02h at %0t", curReq, statusByte, e, $time);
    end
    checks++;
    if (anyDelta !== ea) begin
      bad++;
      $display("FAIL R9 anyDelta actual=%0b expected=%0b at %0t", anyDelta, ea, $time);
    end
  endtask

  task automatic advanceModel();
    if (!rstN) begin
      mCar = 1; mRing = 0; mDsr = 1; mCts = 1;
      fCar = 0; fRing = 0; fDsr = 0; fCts = 0;
    end else if (!loopEn) begin
      if (rdStb) begin fCar = 0; fRing = 0; fDsr = 0; fCts = 0; end
      if (mCar != dcdIn) fCar = 1;
      if (mDsr != dsrIn) fDsr = 1;
      if (mCts != ctsIn) fCts = 1;
      if (mRing && !riIn) fRing = 1;
      mCar = dcdIn; mRing = riIn; mDsr = dsrIn; mCts = ctsIn;
    end
  endtask

  // inputs already applied after a falling edge: check, advance, wait
  task automatic tick();
    #1;
    if (rstN) checkNow();
    advanceModel();
    @(negedge clk);
  endtask

  task automatic setPins(input bit car, input bit ring, input bit dsr, input bit cts);
    dcdIn = car; riIn = ring; dsrIn = dsr; ctsIn = cts;
  endtask

  task automatic expectByte(input logic [7:0] e, input string req);
    #1;
    checks++;
    if (statusByte !== e) begin
      bad++;
      $display("FAIL %s explicit statusByte actual=%02h expected=%02h", req, statusByte, e);
    end
  endtask

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rstN = 1'b1;

    // R1: reset value before any activity
    curReq = "R1";
    expectByte(8'hB0, "R1");
    tick();

    // R2: cts drops, flag appears after the edge
    curReq = "R2";
    setPins(1, 0, 1, 0);
    tick();
    expectByte(8'hA1, "R2");
    tick();

    // R4: read returns flags, cleared after
    curReq = "R4";
    rdStb = 1;
    expectByte(8'hA1, "R4");
    tick();
    rdStb = 0;
    expectByte(8'hA0, "R4");
    tick();

    // R3: ring rises -> no flag; ring falls -> flag
    curReq = "R3";
    setPins(1, 1, 1, 0);
    tick();
    expectByte(8'hE0, "R3");
    tick();
    setPins(1, 0, 1, 0);
    tick();
    expectByte(8'hA4, "R3");
    rdStb = 1;
    tick();
    rdStb = 0;

    // R6: accumulate dsr then carrier, dsr toggles back
    curReq = "R6";
    setPins(1, 0, 0, 0); tick();
    setPins(0, 0, 0, 0); tick();
    setPins(0, 0, 1, 0); tick();
    expectByte(8'h2A, "R6");
    tick();

    // R5: read coinciding with a ring fall and a cts change
    curReq = "R5";
    rdStb = 1; tick(); rdStb = 0; tick();
    setPins(0, 1, 1, 0); tick();
    rdStb = 1;
    setPins(0, 0, 1, 1);
    tick();
    rdStb = 0;
    expectByte(8'h35, "R5");
    tick();
    rdStb = 1; tick(); rdStb = 0;

    // R7: loopback mapping of the control outputs
    curReq = "R7";
    loopEn = 1;
    for (int m = 0; m < 16; m++) begin
      mcrBits = m[3:0];
      tick();
    end
    mcrBits = 4'b0010;
    expectByte(8'h10, "R7");
    mcrBits = 4'b0001;
    expectByte(8'h20, "R7");

    // R8: pins ignored, read does not clear, exit compares held levels
    curReq = "R8";
    setPins(1, 1, 0, 0); tick();
    setPins(1, 0, 0, 0); tick();
    rdStb = 1; tick(); rdStb = 0;
    loopEn = 0;
    expectByte(8'h30, "R8");
    tick();
    expectByte(8'h8B, "R8");
    rdStb = 1; tick(); rdStb = 0;
    setPins(1, 1, 0, 0); tick();
    loopEn = 1; tick();
    setPins(1, 0, 0, 0); tick();
    loopEn = 0;
    tick();
    expectByte(8'h84, "R8");
    tick();

    // random soak over all requirements (R2 R3 R4 R5 R6 R8 R9)
    curReq = "R2";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom;
      setPins(r[0] ^ dcdIn & r[4], r[1] ^ riIn & r[5], r[2] ^ dsrIn & r[6], r[3] ^ ctsIn & r[7]);
      rdStb = (r[10:8] == 3'd0);
      loopEn = (r[15:12] == 4'd0) ? ~loopEn : loopEn;
      mcrBits = r[19:16];
      curReq = loopEn ? "R8" : "R6";
      tick();
    end
    rdStb = 0; loopEn = 0;
    tick();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule